// File: doc/BRIEF.md
# Programmable trigger pulse generator

This block produces the trigger pulse and the trigger type handed to a trigger controller. Three internal request sources feed one pulse shaper. A periodic generator divides a base interval by a power of two. A self-trigger generator divides its own base interval by a 20-bit linear rate. A software trigger fires when a configuration bit goes 1 and then back to 0. A second bit, toggled the same way, requests a double pulse.

The shaper sets the pulse length from a 4-bit code with a piecewise mapping. Codes 0 to 6 give a long pulse: a fixed offset plus the code, in length steps. Codes 7 to 15 give a short pulse of (code − 7) steps, so code 7 suppresses output. A double pulse is two pulses of the same length, with an idle gap of that length between them.

The trigger type comes from the standard selection logic unless an override field supplies a fixed 4-bit code. Time quantities are parameters in clock cycles:
- the base interval of the periodic generator;
- the prescale of the self-trigger generator;
- the length step;
- the long-pulse offset.

Top module: `trg_pulse_gen`

## Requirements
- R1: With `cfg_pgen_en`=1 and exponent e on `cfg_pgen_exp`, pulses start every PGEN_BASE_CYCLES·2^e cycles. With `cfg_pgen_en`=0 the periodic generator starts no pulse.
- R2: With `cfg_self_rate`=N≠0, pulses start every N·SELF_PRESCALE cycles. N=0 disables this generator.
- R3: A 1→0 transition of `cfg_sw_fire` starts exactly one pulse. Holding the bit at 1 or at 0 starts none.
- R4: For `cfg_len_code` below 7, a pulse lasts (LEN_OFFSET+code)·STEP_CYCLES cycles.
- R5: For `cfg_len_code` of 7 or more, a pulse lasts (code−7)·STEP_CYCLES cycles. Code 7 suppresses the pulse entirely.
- R6: A 1→0 transition of `cfg_sw_double` gives a pulse of length L, then L idle cycles, then a second pulse of length L. Rising edges are therefore 2L cycles apart.
- R7: A request that arrives while a pulse (or a double-pulse gap) is in progress is dropped. Every pulse is followed by at least one low cycle.
- R8: When `cfg_type_ovr[4]`=1, `trig_type` equals `cfg_type_ovr[3:0]`. Otherwise it equals `std_type`.
- R9: During and directly after reset, `trig_out` is 0.
- R10: `trig_out` rises in the clock cycle after the cycle in which the software bit reads 0 following a 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pgen_en | input | 1 | Periodic generator enable |
| cfg_pgen_exp | input | 4 | Power-of-two divide exponent |
| cfg_self_rate | input | 20 | Linear rate of the self-trigger generator, 0 = off |
| cfg_sw_fire | input | 1 | Software single-pulse bit |
| cfg_sw_double | input | 1 | Software double-pulse bit |
| cfg_len_code | input | 4 | Pulse length code |
| cfg_type_ovr | input | 5 | Bit 4 = override enable, bits 3:0 = fixed type |
| std_type | input | 4 | Type from the standard selection logic |
| trig_out | output | 1 | Trigger pulse |
| trig_type | output | 4 | Trigger type |

## Verification
The bench builds the block with PGEN_BASE_CYCLES=8, SELF_PRESCALE=2, STEP_CYCLES=1 and LEN_OFFSET=10. With these values every exponent up to 3 gives a period of at most 64 cycles, and the self-trigger rate of 1 reaches the two-cycle back-to-back limit. A one-cycle step also makes each of the sixteen length codes a distinct, short and exactly countable width. Random length codes, rates, exponents and types are mixed with directed cases:
- code 7;
- a rate of 0;
- a held software bit;
- a software toggle during a running pulse.

// File: rtl/trg_pkg.sv
package trg_pkg;

   typedef enum logic [1:0] {
      SH_IDLE   = 2'd0,
      SH_PULSE1 = 2'd1,
      SH_GAP    = 2'd2,
      SH_PULSE2 = 2'd3
   } shape_st_e;

   localparam int unsigned CODE_W    = 4;
   localparam int unsigned LONG_LIM  = 7;

   // Piecewise length code: long range adds an offset, short range starts at 7.
   function automatic int unsigned trg_len_units(input logic [CODE_W-1:0] code,
                                                 input int unsigned offset);
      if (32'(code) < LONG_LIM)
         return offset + 32'(code);
      else
         return 32'(code) - LONG_LIM;
   endfunction

endpackage

// File: rtl/trg_ratediv.sv
module trg_ratediv #(
   parameter int unsigned PRESCALE = 2,
   parameter int unsigned PERIOD_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PERIOD_W-1:0] period_i,
   output logic                tick_o
);
   localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

   logic                run;
   logic                step;
   logic                last;
   logic [PERIOD_W-1:0] cnt;

   generate
      if (PRESCALE < 1) begin : g_bad_prescale
         $error("trg_ratediv: PRESCALE must be at least 1");
      end
      if (PRESCALE == 1) begin : g_direct
         assign step = run;
      end else begin : g_prescaled
         logic [PRE_W-1:0] pre;
         always_ff @(posedge clk) begin
            if (!rst_n)
               pre <= '0;
            else if (!run || pre == PRE_W'(PRESCALE - 1))
               pre <= '0;
            else
               pre <= pre + PRE_W'(1);
         end
         assign step = run && (pre == PRE_W'(PRESCALE - 1));
      end
   endgenerate

   assign run    = (period_i != '0);
   assign last   = ({1'b0, cnt} + (PERIOD_W+1)'(1)) >= {1'b0, period_i};
   assign tick_o = step && last;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || tick_o)
         cnt <= '0;
      else if (step)
         cnt <= cnt + PERIOD_W'(1);
   end

   // R1 R2: each tick restarts the interval count
   p_restart_after_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> (cnt == '0));

endmodule

// File: rtl/trg_swedge.sv
module trg_swedge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic fire_o
);
   logic prev;

   always_ff @(posedge clk) begin
      if (!rst_n)
         prev <= 1'b0;
      else
         prev <= lvl_i;
   end

   assign fire_o = prev && !lvl_i;

   // R3: one request per falling transition
   p_fire_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> !fire_o);

endmodule

// File: rtl/trg_shaper.sv
module trg_shaper
   import trg_pkg::*;
#(
   parameter int unsigned STEP_CYCLES = 1,
   parameter int unsigned LEN_OFFSET  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_single_i,
   input  logic              req_double_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              pulse_o
);
   localparam int unsigned MAX_LEN = (LEN_OFFSET + LONG_LIM - 1) * STEP_CYCLES;
   localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);

   shape_st_e        state;
   logic [LEN_W-1:0] cnt;
   logic [LEN_W-1:0] len_r;
   logic [LEN_W-1:0] len_cyc;
   logic             dbl_r;

   generate
      if (STEP_CYCLES < 1) begin : g_bad_step
         $error("trg_shaper: STEP_CYCLES must be at least 1");
      end
   endgenerate

   always_comb begin
      len_cyc = LEN_W'(trg_len_units(code_i, LEN_OFFSET) * STEP_CYCLES);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SH_IDLE;
         cnt   <= '0;
         len_r <= '0;
         dbl_r <= 1'b0;
      end else begin
         case (state)
            SH_IDLE: begin
               if ((req_single_i || req_double_i) && len_cyc != '0) begin
                  state <= SH_PULSE1;
                  cnt   <= len_cyc - LEN_W'(1);
                  len_r <= len_cyc;
                  dbl_r <= req_double_i;
               end
            end
            SH_PULSE1: begin
               if (cnt == '0) begin
                  if (dbl_r) begin
                     state <= SH_GAP;
                     cnt   <= len_r - LEN_W'(1);
                  end else begin
                     state <= SH_IDLE;
                  end
               end else begin
                  cnt <= cnt - LEN_W'(1);
               end
            end
            SH_GAP: begin
               if (cnt == '0) begin
                  state <= SH_PULSE2;
                  cnt   <= len_r - LEN_W'(1);
               end else begin
                  cnt <= cnt - LEN_W'(1);
               end
            end
            default: begin
               if (cnt == '0)
                  state <= SH_IDLE;
               else
                  cnt <= cnt - LEN_W'(1);
            end
         endcase
      end
   end

   assign pulse_o = (state == SH_PULSE1) || (state == SH_PULSE2);

   // R5: a zero-length code never starts a pulse
   p_zero_len_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SH_IDLE && len_cyc == '0) |=> !pulse_o);
   // R4: a running pulse keeps its latched length until its count runs out
   p_hold_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_o && cnt != '0) |=> (pulse_o && $stable(len_r)));
   // R7: a single pulse is always followed by a low cycle
   p_idle_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SH_PULSE1 && cnt == '0 && !dbl_r) |=> !pulse_o);
   // R6: the double-pulse gap is low and ends in the second pulse
   p_gap_then_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SH_GAP && cnt == '0) |=> pulse_o);

endmodule

// File: rtl/trg_pulse_gen.sv
module trg_pulse_gen
   import trg_pkg::*;
#(
   parameter int unsigned PGEN_BASE_CYCLES = 128,
   parameter int unsigned SELF_PRESCALE    = 2,
   parameter int unsigned STEP_CYCLES      = 1,
   parameter int unsigned LEN_OFFSET       = 10,
   parameter int unsigned EXP_W            = 4,
   parameter int unsigned RATE_W           = 20,
   parameter int unsigned TYPE_W           = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_pgen_en,
   input  logic [EXP_W-1:0]  cfg_pgen_exp,
   input  logic [RATE_W-1:0] cfg_self_rate,
   input  logic              cfg_sw_fire,
   input  logic              cfg_sw_double,
   input  logic [CODE_W-1:0] cfg_len_code,
   input  logic [TYPE_W:0]   cfg_type_ovr,
   input  logic [TYPE_W-1:0] std_type,
   output logic              trig_out,
   output logic [TYPE_W-1:0] trig_type
);
   localparam int unsigned PGEN_PER_W = 1 << EXP_W;

   logic [PGEN_PER_W-1:0] pgen_period;
   logic                  pgen_tick;
   logic                  self_tick;
   logic                  sw_single;
   logic                  sw_double;

   generate
      if (PGEN_BASE_CYCLES < 1 || SELF_PRESCALE < 1) begin : g_bad_base
         $error("trg_pulse_gen: base intervals must be at least 1");
      end
      if (EXP_W > 5) begin : g_bad_exp
         $error("trg_pulse_gen: EXP_W too large for a shifted period");
      end
   endgenerate

   assign pgen_period = cfg_pgen_en ? (PGEN_PER_W'(1) << cfg_pgen_exp) : '0;

   trg_ratediv #(.PRESCALE(PGEN_BASE_CYCLES), .PERIOD_W(PGEN_PER_W)) i_pgen (
      .clk(clk), .rst_n(rst_n), .period_i(pgen_period), .tick_o(pgen_tick));

   trg_ratediv #(.PRESCALE(SELF_PRESCALE), .PERIOD_W(RATE_W)) i_self (
      .clk(clk), .rst_n(rst_n), .period_i(cfg_self_rate), .tick_o(self_tick));

   trg_swedge i_sw_single (
      .clk(clk), .rst_n(rst_n), .lvl_i(cfg_sw_fire), .fire_o(sw_single));

   trg_swedge i_sw_double (
      .clk(clk), .rst_n(rst_n), .lvl_i(cfg_sw_double), .fire_o(sw_double));

   trg_shaper #(.STEP_CYCLES(STEP_CYCLES), .LEN_OFFSET(LEN_OFFSET)) i_shaper (
      .clk(clk), .rst_n(rst_n),
      .req_single_i(pgen_tick || self_tick || sw_single),
      .req_double_i(sw_double),
      .code_i(cfg_len_code),
      .pulse_o(trig_out));

   assign trig_type = cfg_type_ovr[TYPE_W] ? cfg_type_ovr[TYPE_W-1:0] : std_type;

   // R9: the output is low in the first cycle after reset
   p_low_after_reset_r9: assert property (@(posedge clk)
      !rst_n |=> !trig_out);

endmodule

// File: tb/test_trg_pulse_gen.sv
module test_trg_pulse_gen;
   localparam int PB = 8;
   localparam int SP = 2;
   localparam int ST = 1;
   localparam int LO = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_pgen_en = 1'b0;
   logic [3:0]  cfg_pgen_exp = '0;
   logic [19:0] cfg_self_rate = '0;
   logic        cfg_sw_fire = 1'b0;
   logic        cfg_sw_double = 1'b0;
   logic [3:0]  cfg_len_code = '0;
   logic [4:0]  cfg_type_ovr = '0;
   logic [3:0]  std_type = '0;
   logic        trig_out;
   logic [3:0]  trig_type;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int cyc = 0;
   int rise_cnt = 0;
   int rise_at = 0;
   int prev_rise_at = 0;
   int cur_w = 0;
   int w_last = 0;
   int w_prev = 0;
   logic seen = 1'b0;

   trg_pulse_gen #(.PGEN_BASE_CYCLES(PB), .SELF_PRESCALE(SP),
                   .STEP_CYCLES(ST), .LEN_OFFSET(LO)) i_trg_pulse_gen (
      .clk(clk), .rst_n(rst_n), .cfg_pgen_en(cfg_pgen_en),
      .cfg_pgen_exp(cfg_pgen_exp), .cfg_self_rate(cfg_self_rate),
      .cfg_sw_fire(cfg_sw_fire), .cfg_sw_double(cfg_sw_double),
      .cfg_len_code(cfg_len_code), .cfg_type_ovr(cfg_type_ovr),
      .std_type(std_type), .trig_out(trig_out), .trig_type(trig_type));

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (trig_out && !seen) begin
            prev_rise_at = rise_at;
            rise_at = cyc;
            rise_cnt++;
            cur_w = 1;
         end else if (trig_out) begin
            cur_w++;
         end else if (seen) begin
            w_prev = w_last;
            w_last = cur_w;
         end
         seen = trig_out;
      end
   end

   function automatic int exp_len(input int code);
      return (code < 7) ? (LO + code) * ST : (code - 7) * ST;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic wait_rises(input int target);
      for (int k = 0; k < 3000 && rise_cnt < target; k++) @(negedge clk);
   endtask

   // Toggle a software bit 1 then 0; returns cycle count at the falling write.
   task automatic sw_toggle(input bit dbl, output int n);
      @(negedge clk);
      if (dbl) cfg_sw_double = 1'b1; else cfg_sw_fire = 1'b1;
      repeat (2) @(negedge clk);
      if (dbl) cfg_sw_double = 1'b0; else cfg_sw_fire = 1'b0;
      n = cyc;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      int n, c0, code, L, e, rate, t;
      void'($urandom(32'd20240611));

      repeat (4) @(negedge clk);
      check(trig_out == 1'b0, "R9 in reset", trig_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(trig_out == 1'b0, "R9 after reset", trig_out, 0);

      // long codes, single software trigger with latency
      for (int i = 0; i < 5; i++) begin
         code = (i == 0) ? 0 : (i == 1) ? 6 : $urandom_range(0, 6);
         cfg_len_code = 4'(code);
         c0 = rise_cnt;
         sw_toggle(1'b0, n);
         repeat (exp_len(code) + 6) @(negedge clk);
         check(rise_cnt == c0 + 1, "R3 one pulse", rise_cnt - c0, 1);
         check(rise_at == n + 1, "R10 latency", rise_at, n + 1);
         check(w_last == exp_len(code), "R4 long width", w_last, exp_len(code));
      end

      // short codes, including suppression at code 7
      for (int i = 0; i < 6; i++) begin
         code = (i == 0) ? 7 : (i == 1) ? 15 : $urandom_range(7, 15);
         cfg_len_code = 4'(code);
         c0 = rise_cnt;
         sw_toggle(1'b0, n);
         repeat (exp_len(code) + 6) @(negedge clk);
         if (code == 7) begin
            check(rise_cnt == c0, "R5 code 7 suppressed", rise_cnt - c0, 0);
         end else begin
            check(rise_cnt == c0 + 1, "R5 one pulse", rise_cnt - c0, 1);
            check(w_last == exp_len(code), "R5 short width", w_last, exp_len(code));
         end
      end

      // held bit starts nothing
      cfg_len_code = 4'd9;
      c0 = rise_cnt;
      @(negedge clk) cfg_sw_fire = 1'b1;
      repeat (40) @(negedge clk);
      check(rise_cnt == c0, "R3 held high", rise_cnt - c0, 0);
      cfg_sw_fire = 1'b0;
      repeat (10) @(negedge clk);
      c0 = rise_cnt;
      repeat (40) @(negedge clk);
      check(rise_cnt == c0, "R3 held low", rise_cnt - c0, 0);

      // double pulse
      for (int i = 0; i < 4; i++) begin
         code = (i == 0) ? 8 : (i == 1) ? 3 : $urandom_range(8, 15);
         L = exp_len(code);
         cfg_len_code = 4'(code);
         c0 = rise_cnt;
         sw_toggle(1'b1, n);
         repeat (3 * L + 6) @(negedge clk);
         check(rise_cnt == c0 + 2, "R6 two pulses", rise_cnt - c0, 2);
         check(rise_at - prev_rise_at == 2 * L, "R6 spacing", rise_at - prev_rise_at, 2 * L);
         check(w_last == L && w_prev == L, "R6 widths", w_prev * 100 + w_last, L * 101);
      end

      // request during busy pulse is dropped
      cfg_len_code = 4'd6;
      c0 = rise_cnt;
      sw_toggle(1'b0, n);
      repeat (3) @(negedge clk);
      cfg_sw_fire = 1'b1;
      repeat (2) @(negedge clk);
      cfg_sw_fire = 1'b0;
      repeat (exp_len(6) + 10) @(negedge clk);
      check(rise_cnt == c0 + 1, "R7 busy drop", rise_cnt - c0, 1);
      check(w_last == exp_len(6), "R7 width kept", w_last, exp_len(6));

      // periodic generator
      cfg_len_code = 4'd8;
      for (int i = 0; i < 4; i++) begin
         e = (i < 3) ? i : $urandom_range(0, 3);
         cfg_pgen_exp = 4'(e);
         cfg_pgen_en = 1'b1;
         c0 = rise_cnt;
         wait_rises(c0 + 3);
         check(rise_at - prev_rise_at == (PB << e), "R1 period",
               rise_at - prev_rise_at, PB << e);
         @(negedge clk) cfg_pgen_en = 1'b0;
         repeat (3) @(negedge clk);
         c0 = rise_cnt;
         repeat (200) @(negedge clk);
         check(rise_cnt == c0, "R1 disabled", rise_cnt - c0, 0);
      end

      // self-trigger generator
      for (int i = 0; i < 4; i++) begin
         rate = (i == 0) ? 1 : $urandom_range(4, 30);
         cfg_self_rate = 20'(rate);
         c0 = rise_cnt;
         wait_rises(c0 + 3);
         check(rise_at - prev_rise_at == rate * SP, "R2 period",
               rise_at - prev_rise_at, rate * SP);
         @(negedge clk) cfg_self_rate = '0;
         repeat (3) @(negedge clk);
         c0 = rise_cnt;
         repeat (200) @(negedge clk);
         check(rise_cnt == c0, "R2 rate zero", rise_cnt - c0, 0);
      end

      // trigger type override
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         t = $urandom_range(0, 31);
         cfg_type_ovr = 5'(t);
         std_type = 4'($urandom_range(0, 15));
         #1;
         if (t >= 16)
            check(trig_type == 4'(t), "R8 override", trig_type, t & 15);
         else
            check(trig_type == std_type, "R8 standard", trig_type, std_type);
      end

      finish_run();
   end
endmodule